// File: doc/BRIEF.md
# Encoded Interrupt Level Input Filter

This block sits between a four-wire encoded interrupt input and the processor core. An external priority encoder drives the wires with an inverted code. Code 0000 is the most urgent request and code 1111 means that nothing is requested. The block first passes the wires through a two-flop synchronizer. It then lets a new code through only after that code has been seen on consecutive samples of the peripheral clock, so a short glitch on the wires never reaches the core.

The filtered code is turned into a priority level, 15 minus the code. That level is compared against the four-bit interrupt mask taken from the processor status register. A request goes to the core only while the level is strictly above the mask. The block only reads the mask and has no way to change it.

The pending level can climb while it waits for acceptance: a higher level replaces it, and a lower level that is still above the mask does not. When the core pulses its acknowledge input, the pending level is copied to an accepted-level output and a one-cycle strobe marks the copy. A one-cycle wake pulse on each rising edge of the request lets standby logic resume the system.

Top module: `enc_irq_filter`

## Requirements
- R1: The pending level reported on `pend_lvl` equals 15 minus the filtered four-bit code. Code 1111 means level 0 (no request), code 1110 means level 1, and code 0000 means level 15.
- R2: While `rst` is high and after it is released, the filtered code is 1111, and `irq_req`, `pend_lvl`, `acc_lvl`, `acc_stb` and `wake_req` are all zero.
- R3: A code held on `irl_code` for two consecutive rising edges of `clk` is accepted. When the first of those edges is e1, `irq_req` and `pend_lvl` reflect the new code after edge e5 and not after edge e4.
- R4: A code that is present on `irl_code` for only one rising edge of `clk` never changes `irq_req` or `pend_lvl`.
- R5: `irq_req` is raised only while the level is strictly greater than `sr_mask`. If the level equals the mask, `irq_req` stays low and `pend_lvl` is 0.
- R6: When the level falls to or below `sr_mask`, `irq_req` and `pend_lvl` read 0 after the next rising edge of `clk`.
- R7: While a request is outstanding and not acknowledged, a higher level replaces `pend_lvl`. A lower level that is still above the mask leaves `pend_lvl` at the highest level seen.
- R8: An `ack` sampled high while `irq_req` is high makes `acc_stb` high for exactly one cycle, with `acc_lvl` equal to the `pend_lvl` value before that edge. `pend_lvl` then reloads from the current level, and `acc_lvl` holds its value until the next accepted acknowledge.
- R9: An `ack` sampled while `irq_req` is low produces no `acc_stb` and leaves `acc_lvl` unchanged.
- R10: `wake_req` is high for exactly the one cycle in which `irq_req` goes from low to high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock; all sampling happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irl_code | input | 4 | Asynchronous inverted priority code from the external encoder |
| sr_mask | input | 4 | Interrupt mask from the processor status register (read only) |
| ack | input | 1 | One-cycle acceptance pulse from the core |
| irq_req | output | 1 | Interrupt request to the core |
| pend_lvl | output | 4 | Priority level of the outstanding request, 0 when none |
| acc_lvl | output | 4 | Level captured at the last accepted acknowledge |
| acc_stb | output | 1 | One-cycle strobe marking a new value on `acc_lvl` |
| wake_req | output | 1 | One-cycle standby wake pulse on a rising request |

## Verification
The hardest situation to reach from the ports is the sticky pending level. It shows only when a request is already outstanding, the code then moves to a higher level, and it then drops back to a lower level that is still above the mask, all before any acknowledge. The stimulus reaches this state by holding the mask fixed and stepping the code through three values, letting each one settle past the filter latency. It then acknowledges and checks that the captured level is the peak while the pending level reloads from the current one. Glitch rejection is driven at exactly one sampled edge, from both an idle and an active state. A two-edge pulse is also driven to show where the acceptance boundary lies.

// File: rtl/lvl_pkg.sv
package lvl_pkg;

    localparam int CODE_W = 4;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CODE_W-1:0] level_t;

    localparam code_t IDLE_CODE = '1;

    typedef struct packed {
        logic   req;
        level_t lvl;
    } pend_t;

    typedef struct packed {
        logic   stb;
        level_t lvl;
    } accept_t;

    // Inverted priority code: level = max code - code
    function automatic level_t code_to_level(input code_t c);
        return level_t'(IDLE_CODE - c);
    endfunction

    function automatic level_t level_max(input level_t a, input level_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lvl_sync.sv
module lvl_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/lvl_filter.sv
module lvl_filter #(
    parameter int           W       = 4,
    parameter int           MATCH   = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int            CW       = $clog2(MATCH) + 1;
    localparam logic [CW-1:0] LAST_RUN = CW'(MATCH - 1);

    logic [W-1:0]  last_q;
    logic [CW-1:0] run_q;
    logic [CW-1:0] run_nx;
    logic [W-1:0]  out_q;
    logic          same;
    logic          load;

    always_comb begin
        same = (din == last_q);
        if (!same)                 run_nx = '0;
        else if (run_q == LAST_RUN) run_nx = run_q;
        else                       run_nx = run_q + CW'(1);
        load = same && (run_nx == LAST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= RST_VAL;
            run_q  <= '0;
            out_q  <= RST_VAL;
        end else begin
            last_q <= din;
            run_q  <= run_nx;
            if (load) out_q <= din;
        end
    end

    assign dout = out_q;

endmodule

// File: rtl/lvl_qualify.sv
module lvl_qualify
    import lvl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  code_t   code,
    input  level_t  mask,
    input  logic    ack,
    output pend_t   pend_o,
    output accept_t acc_o,
    output logic    wake_o
);

    level_t  level;
    logic    above;
    logic    take;
    pend_t   pend_q, pend_nx;
    accept_t acc_q, acc_nx;
    logic    wake_q;

    always_comb begin
        level = code_to_level(code);
        above = level > mask;
        take  = ack && pend_q.req;

        if (!above) begin
            pend_nx = '0;
        end else if (take) begin
            pend_nx.req = 1'b1;
            pend_nx.lvl = level;
        end else begin
            pend_nx.req = 1'b1;
            pend_nx.lvl = level_max(pend_q.lvl, level);
        end

        if (take) begin
            acc_nx.stb = 1'b1;
            acc_nx.lvl = pend_q.lvl;
        end else begin
            acc_nx.stb = 1'b0;
            acc_nx.lvl = acc_q.lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            acc_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            pend_q <= pend_nx;
            acc_q  <= acc_nx;
            wake_q <= pend_nx.req && !pend_q.req;
        end
    end

    assign pend_o = pend_q;
    assign acc_o  = acc_q;
    assign wake_o = wake_q;

endmodule

// File: rtl/enc_irq_filter.sv
module enc_irq_filter
    import lvl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MATCH       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] irl_code,
    input  logic [CODE_W-1:0] sr_mask,
    input  logic              ack,
    output logic              irq_req,
    output logic [CODE_W-1:0] pend_lvl,
    output logic [CODE_W-1:0] acc_lvl,
    output logic              acc_stb,
    output logic              wake_req
);

    code_t   sync_code;
    code_t   filt_code;
    pend_t   pend;
    accept_t accepted;
    logic    wake;

    lvl_sync #(
        .W      (CODE_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IDLE_CODE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (irl_code),
        .dout(sync_code)
    );

    lvl_filter #(
        .W      (CODE_W),
        .MATCH  (MATCH),
        .RST_VAL(IDLE_CODE)
    ) u_filt (
        .clk (clk),
        .rst (rst),
        .din (sync_code),
        .dout(filt_code)
    );

    lvl_qualify u_qual (
        .clk   (clk),
        .rst   (rst),
        .code  (filt_code),
        .mask  (sr_mask),
        .ack   (ack),
        .pend_o(pend),
        .acc_o (accepted),
        .wake_o(wake)
    );

    assign irq_req  = pend.req;
    assign pend_lvl = pend.lvl;
    assign acc_lvl  = accepted.lvl;
    assign acc_stb  = accepted.stb;
    assign wake_req = wake;

endmodule

// File: rtl/enc_irq_filter_chk.sv
module enc_irq_filter_chk
    import lvl_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   ack,
    input logic   irq_req,
    input level_t pend_lvl,
    input level_t acc_lvl,
    input logic   acc_stb,
    input logic   wake_req,
    input level_t sr_mask,
    input code_t  sync_code,
    input code_t  filt_code
);

    // R1
    req_has_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (pend_lvl != '0));

    // R3
    filt_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (filt_code != $past(filt_code)) |-> ($past(sync_code) == filt_code));

    // R6
    drop_below_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (code_to_level(filt_code) <= sr_mask) |=> (!irq_req && pend_lvl == '0));

    // R7
    pend_no_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !ack && code_to_level(filt_code) > sr_mask) |=> (pend_lvl >= $past(pend_lvl)));

    // R8
    ack_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_req) |=> (acc_stb && acc_lvl == $past(pend_lvl)));

    // R9
    ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq_req) |=> (!acc_stb && $stable(acc_lvl)));

    // R10
    wake_edge_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (irq_req && !$past(irq_req)));

    // R10
    wake_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !$past(irq_req)) |-> wake_req);

endmodule

bind enc_irq_filter enc_irq_filter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack      (ack),
    .irq_req  (irq_req),
    .pend_lvl (pend_lvl),
    .acc_lvl  (acc_lvl),
    .acc_stb  (acc_stb),
    .wake_req (wake_req),
    .sr_mask  (sr_mask),
    .sync_code(sync_code),
    .filt_code(filt_code)
);

// File: tb/sim_enc_irq_filter.sv
`timescale 1ns/1ps
module sim_enc_irq_filter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] irl_code = 4'hF;
    logic [3:0] sr_mask = 4'h0;
    logic       ack = 1'b0;
    logic       irq_req;
    logic [3:0] pend_lvl;
    logic [3:0] acc_lvl;
    logic       acc_stb;
    logic       wake_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        string tag;
        bit    req;
        int    pend;
        int    accl;
        bit    stb;
        bit    wake;
    } exp_t;

    exp_t sb_q[$];
    int   acc_e = 0;

    always #10 clk = ~clk;

    enc_irq_filter u0 (
        .clk     (clk),
        .rst     (rst),
        .irl_code(irl_code),
        .sr_mask (sr_mask),
        .ack     (ack),
        .irq_req (irq_req),
        .pend_lvl(pend_lvl),
        .acc_lvl (acc_lvl),
        .acc_stb (acc_stb),
        .wake_req(wake_req)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input string tag, input bit r, input int p, input bit s, input bit w);
        exp_t e;
        e.tag = tag; e.req = r; e.pend = p; e.accl = acc_e; e.stb = s; e.wake = w;
        sb_q.push_back(e);
    endtask

    // monitor: compares at the falling edge after each expectation was queued
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (irq_req !== e.req || int'(pend_lvl) != e.pend || int'(acc_lvl) != e.accl ||
                    acc_stb !== e.stb || wake_req !== e.wake) begin
                    errors++;
                    $display("FAIL %s: got req=%0b pend=%0d acc=%0d stb=%0b wake=%0b, exp req=%0b pend=%0d acc=%0d stb=%0b wake=%0b",
                             e.tag, irq_req, pend_lvl, acc_lvl, acc_stb, wake_req,
                             e.req, e.pend, e.accl, e.stb, e.wake);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        push("R2 reset state", 0, 0, 0, 0);

        // R3 latency and R10 wake pulse, level 5 over mask 3
        sr_mask = 4'd3; irl_code = 4'hA;
        tick(4); push("R3 not yet after 4 edges", 0, 0, 0, 0);
        tick(1); push("R3 request after 5 edges", 1, 5, 0, 1);
        tick(1); push("R10 wake lasts one cycle", 1, 5, 0, 0);

        // R5 strict comparison
        sr_mask = 4'd5;
        tick(1); push("R5 equal mask blocks", 0, 0, 0, 0);
        sr_mask = 4'd4;
        tick(1); push("R5 level above mask", 1, 5, 0, 1);

        // R4 single-edge glitch while active
        irl_code = 4'h0;
        tick(1);
        irl_code = 4'hA;
        for (int i = 0; i < 8; i++) begin
            tick(1); push("R4 glitch while active", 1, 5, 0, 0);
        end

        // R7 rise to 12, then lower to 7 keeps 12
        irl_code = 4'h3;
        tick(4); push("R7 before rise", 1, 5, 0, 0);
        tick(1); push("R7 rise to higher", 1, 12, 0, 0);
        irl_code = 4'h8;
        tick(6); push("R7 lower level held at peak", 1, 12, 0, 0);

        // R8 acknowledge
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        acc_e = 12;
        push("R8 accept strobe", 1, 7, 1, 0);
        tick(1); push("R8 strobe one cycle", 1, 7, 0, 0);

        // R6 mask raised to 9 above level 7
        sr_mask = 4'd9;
        tick(1); push("R6 drop on mask raise", 0, 0, 0, 0);

        // R9 acknowledge without request
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        push("R9 ack ignored", 0, 0, 0, 0);
        tick(1); push("R9 acc level kept", 0, 0, 0, 0);

        // R4 single-edge glitch from idle
        irl_code = 4'hF;
        tick(6);
        sr_mask = 4'd4;
        tick(1); push("R4 idle before glitch", 0, 0, 0, 0);
        irl_code = 4'h0;
        tick(1);
        irl_code = 4'hF;
        for (int i = 0; i < 8; i++) begin
            tick(1); push("R4 glitch from idle", 0, 0, 0, 0);
        end

        // R3 two-edge pulse is accepted, level 15
        irl_code = 4'h0;
        tick(2);
        irl_code = 4'hF;
        tick(3); push("R3 two-sample pulse accepted", 1, 15, 0, 1);
        tick(6); push("R6 back to idle", 0, 0, 0, 0);

        // R1 lowest nonzero level
        sr_mask = 4'd0; irl_code = 4'hE;
        tick(5); push("R1 code 1110 gives level 1", 1, 1, 0, 1);
        irl_code = 4'hF;
        tick(6); push("R1 code 1111 gives none", 0, 0, 0, 0);

        tick(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule